// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a synthesizable synchronous SRAM with an interface that never needs an idle cycle between a read and a write. All addresses, controls and write data are sampled on the rising clock edge. The only exceptions are the output enable and the sleep input, which gate the data bus without waiting for the clock. A read returns its word two enabled edges after the command, through an output register. A write takes its data two enabled edges after its command. Because a read and a write spend the same time in the pipeline, a host can issue any mix of reads and writes on consecutive cycles.

A write is only committed to the array when its data arrives. A read that follows that write closely can therefore reach the array before the write has landed. The block forwards the pending write data into the read result, lane by lane. A load command takes a new external address. An advance command steps a two-bit burst counter over the low address bits, in linear or interleaved order, and keeps the direction of the command that started the burst. A clock enable freezes the whole pipeline. Three chip selects allow several devices to share one bus.

Top module: `zbt_sram`

## Requirements
- R1: A selected read loaded at enabled edge n drives its word on `dq_out` with `dq_oe`=1 from enabled edge n+2 until the next enabled edge, provided `oe_n`=0 and `sleep`=0.
- R2: A selected write loaded at enabled edge n takes `dq_in` at enabled edge n+2. It writes only the lanes whose `byte_en_n` bit was 0 at edge n. Lane i is `dq` bits [9i+8:9i]. The other lanes keep their contents.
- R3: Reads and writes can be mixed on consecutive cycles with no idle cycle. A read returns the newest data, with lanes merged, even when its address matches a write issued one cycle earlier whose data has not yet reached the array.
- R4: While `clk_en`=0, no edge changes any state. The output word and its valid state are held, and no command is accepted.
- R5: A command is accepted only with `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A deselected load leaves memory unchanged. It produces `dq_oe`=0 in the cycle where read data would have appeared. Write cycles also leave `dq_oe`=0.
- R6: `oe_n`=1 forces `dq_oe`=0 at once, without a clock edge, and read data already captured reappears when `oe_n` returns to 0.
- R7: While `sleep`=1, `dq_oe` is 0, and loads and advances sampled with `sleep`=1 are ignored: they write nothing, read nothing and end any burst.
- R8: With `adv_ld`=0 the block loads `addr` with direction from `wr_n` (0 = write). With `adv_ld`=1 it issues the next burst address with the loaded direction and the current `byte_en_n`, ignoring `addr`, `wr_n` and the chip selects. The low two address bits of beat k are (a+k) mod 4 when `lin_burst`=1 and a XOR k when `lin_burst`=0. Here a is the loaded low bits and the upper bits are kept.
- R9: An advance with no burst in progress (after reset, a deselected load, or a sleep cycle) is a deselected cycle.
- R10: After reset, `dq_oe` is 0 and the pipeline holds no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| clk_en | input | 1 | Clock enable; 0 suspends the pipeline |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load external address, 1 = advance burst |
| wr_n | input | 1 | Direction on load: 0 write, 1 read |
| byte_en_n | input | LANES | Per-lane write enable, active low |
| addr | input | ADDR_W | Word address |
| lin_burst | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down request |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
On every cycle, the assertions check the output gating by `oe_n` and `sleep`. They also check that a read in the second pipeline stage always produces a valid output word, that any other cycle leaves the output invalid, and that a suspended clock holds the output register. Only the bench scenarios can show that the data is correct. This covers lane-merged forwarding from a write one cycle older, ordering across stalls, the linear and interleaved burst address sequences, and the fact that commands given while deselected or asleep leave memory untouched.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } zbt_op_e;
endpackage

// File: rtl/zbt_burst_ctl.sv
`timescale 1ns/1ps
// Command decode and burst address generation; first pipeline stage.
module zbt_burst_ctl #(
   parameter int ADDR_W  = 8,
   parameter int LANES   = 4,
   parameter int BURST_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clk_en,
   input  logic                 sleep,
   input  logic                 sel_ok,
   input  logic                 adv_ld,
   input  logic                 wr_n,
   input  logic                 lin_burst,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [LANES-1:0]     byte_en_n,
   output zbt_pkg::zbt_op_e     s1_op,
   output logic [ADDR_W-1:0]    s1_addr,
   output logic [LANES-1:0]     s1_be
);
   import zbt_pkg::*;

   logic                 brst_act, n_act;
   zbt_op_e              brst_dir, n_dir, n_op;
   logic [ADDR_W-1:0]    brst_base, n_base, n_addr;
   logic [BURST_W-1:0]   brst_cnt, n_cnt, n_lo;

   always_comb begin
      n_op   = OP_IDLE;
      n_act  = 1'b0;
      n_dir  = brst_dir;
      n_base = brst_base;
      n_cnt  = brst_cnt;
      if (!sleep) begin
         if (!adv_ld) begin
            if (sel_ok) begin
               n_act  = 1'b1;
               n_dir  = wr_n ? OP_READ : OP_WRITE;
               n_base = addr;
               n_cnt  = '0;
               n_op   = n_dir;
            end
         end else if (brst_act) begin
            n_act = 1'b1;
            n_cnt = brst_cnt + BURST_W'(1);
            n_op  = brst_dir;
         end
      end
   end

   generate
      if (BURST_W < 1) begin : g_no_burst
         assign n_lo = n_base[BURST_W-1:0];
      end else begin : g_burst
         assign n_lo = lin_burst ? (n_base[BURST_W-1:0] + n_cnt)
                                 : (n_base[BURST_W-1:0] ^ n_cnt);
      end
   endgenerate

   assign n_addr = {n_base[ADDR_W-1:BURST_W], n_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op     <= OP_IDLE;
         s1_addr   <= '0;
         s1_be     <= '0;
         brst_act  <= 1'b0;
         brst_dir  <= OP_IDLE;
         brst_base <= '0;
         brst_cnt  <= '0;
      end else if (clk_en) begin
         s1_op     <= n_op;
         s1_addr   <= n_addr;
         s1_be     <= ~byte_en_n;
         brst_act  <= n_act;
         brst_dir  <= n_dir;
         brst_base <= n_base;
         brst_cnt  <= n_cnt;
      end
   end
endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
// Lane-split storage: one inferred RAM per byte lane, registered read.
module zbt_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [LANES-1:0]          wbe,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic                      re,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [LANES*LANE_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [LANE_W-1:0] ram [DEPTH];
         logic [LANE_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (we && wbe[i])
               ram[waddr] <= wdata[i*LANE_W +: LANE_W];
            if (re)
               rd_q <= ram[raddr];
         end
         assign rdata[i*LANE_W +: LANE_W] = rd_q;
      end
   endgenerate
endmodule

// File: rtl/zbt_out_stage.sv
`timescale 1ns/1ps
// Second pipeline stage, late-write commit, forwarding and output register.
module zbt_out_stage #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clk_en,
   input  zbt_pkg::zbt_op_e          s1_op,
   input  logic [ADDR_W-1:0]         s1_addr,
   input  logic [LANES-1:0]          s1_be,
   input  logic [LANES*LANE_W-1:0]   dq_in,
   input  logic [LANES*LANE_W-1:0]   arr_rdata,
   output logic                      arr_we,
   output logic [LANES-1:0]          arr_wbe,
   output logic [ADDR_W-1:0]         arr_waddr,
   output logic                      arr_re,
   output logic [ADDR_W-1:0]         arr_raddr,
   output zbt_pkg::zbt_op_e          s2_op,
   output logic                      out_vld,
   output logic [LANES*LANE_W-1:0]   out_data
);
   import zbt_pkg::*;
   localparam int DATA_W = LANES * LANE_W;

   logic [ADDR_W-1:0]  s2_addr;
   logic [LANES-1:0]   s2_be;
   logic               fwd_vld;
   logic [ADDR_W-1:0]  fwd_addr;
   logic [LANES-1:0]   fwd_be;
   logic [DATA_W-1:0]  fwd_data;
   logic [DATA_W-1:0]  merged;
   logic               fwd_hit;

   assign arr_we    = clk_en && (s2_op == OP_WRITE);
   assign arr_wbe   = s2_be;
   assign arr_waddr = s2_addr;
   assign arr_re    = clk_en && (s1_op == OP_READ);
   assign arr_raddr = s1_addr;
   assign fwd_hit   = fwd_vld && (fwd_addr == s2_addr);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_merge
         assign merged[i*LANE_W +: LANE_W] = (fwd_hit && fwd_be[i])
            ? fwd_data[i*LANE_W +: LANE_W]
            : arr_rdata[i*LANE_W +: LANE_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_op    <= OP_IDLE;
         s2_addr  <= '0;
         s2_be    <= '0;
         fwd_vld  <= 1'b0;
         fwd_addr <= '0;
         fwd_be   <= '0;
         fwd_data <= '0;
         out_vld  <= 1'b0;
         out_data <= '0;
      end else if (clk_en) begin
         s2_op    <= s1_op;
         s2_addr  <= s1_addr;
         s2_be    <= s1_be;
         fwd_vld  <= (s2_op == OP_WRITE);
         fwd_addr <= s2_addr;
         fwd_be   <= s2_be;
         fwd_data <= dq_in;
         out_vld  <= (s2_op == OP_READ);
         if (s2_op == OP_READ)
            out_data <= merged;
      end
   end
endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clk_en,
   input  logic                      sel_a_n,
   input  logic                      sel_b,
   input  logic                      sel_c_n,
   input  logic                      adv_ld,
   input  logic                      wr_n,
   input  logic [LANES-1:0]          byte_en_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      lin_burst,
   input  logic                      oe_n,
   input  logic                      sleep,
   input  logic [LANES*LANE_W-1:0]   dq_in,
   output logic [LANES*LANE_W-1:0]   dq_out,
   output logic                      dq_oe
);
   import zbt_pkg::*;
   localparam int DATA_W  = LANES * LANE_W;
   localparam int BURST_W = 2;

   generate
      if (LANES < 1 || LANE_W < 1 || ADDR_W <= BURST_W) begin : g_bad_cfg
         $error("zbt_sram: bad LANES/LANE_W/ADDR_W setting");
      end
   endgenerate

   logic               sel_ok;
   zbt_op_e            s1_op, s2_op;
   logic [ADDR_W-1:0]  s1_addr, arr_waddr, arr_raddr;
   logic [LANES-1:0]   s1_be, arr_wbe;
   logic               arr_we, arr_re;
   logic [DATA_W-1:0]  arr_rdata, out_data;
   logic               out_vld;

   assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

   zbt_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
      .sel_ok(sel_ok), .adv_ld(adv_ld), .wr_n(wr_n), .lin_burst(lin_burst),
      .addr(addr), .byte_en_n(byte_en_n),
      .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
   );

   zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk(clk), .we(arr_we), .wbe(arr_wbe), .waddr(arr_waddr),
      .wdata(dq_in), .re(arr_re), .raddr(arr_raddr), .rdata(arr_rdata)
   );

   zbt_out_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_out (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
      .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
      .dq_in(dq_in), .arr_rdata(arr_rdata),
      .arr_we(arr_we), .arr_wbe(arr_wbe), .arr_waddr(arr_waddr),
      .arr_re(arr_re), .arr_raddr(arr_raddr),
      .s2_op(s2_op), .out_vld(out_vld), .out_data(out_data)
   );

   assign dq_oe  = out_vld && !oe_n && !sleep;
   assign dq_out = dq_oe ? out_data : '0;
endmodule

// File: rtl/zbt_sram_chk.sv
`timescale 1ns/1ps
module zbt_sram_chk #(
   parameter int DATA_W = 36
) (
   input logic                clk,
   input logic                rst_n,
   input logic                clk_en,
   input logic                oe_n,
   input logic                sleep,
   input logic                dq_oe,
   input zbt_pkg::zbt_op_e    s2_op,
   input logic                out_vld,
   input logic [DATA_W-1:0]   out_data
);
   import zbt_pkg::*;

   assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);

   assert_sleep_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_oe);

   assert_rd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && s2_op == OP_READ) |=> out_vld);

   assert_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && s2_op != OP_READ) |=> !out_vld);

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(out_vld) && $stable(out_data)));
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .oe_n(oe_n), .sleep(sleep),
   .dq_oe(dq_oe), .s2_op(s2_op), .out_vld(out_vld), .out_data(out_data)
);

// File: tb/test_zbt_sram.sv
`timescale 1ns/1ps
module test_zbt_sram;
   localparam int AW = 8;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, clk_en, sel_a_n, sel_b, sel_c_n, adv_ld, wr_n, lin_burst, oe_n, sleep;
   logic [NL-1:0] byte_en_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] dq_in, dq_out;
   logic dq_oe;

   zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_zbt_sram (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_a_n(sel_a_n), .sel_b(sel_b),
      .sel_c_n(sel_c_n), .adv_ld(adv_ld), .wr_n(wr_n), .byte_en_n(byte_en_n),
      .addr(addr), .lin_burst(lin_burst), .oe_n(oe_n), .sleep(sleep),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   int checks = 0;
   int bad = 0;
   bit done = 0;
   string cur_req = "R10";

   // ---------------- behavioural reference model ----------------
   typedef struct { int op; int a; logic [NL-1:0] be; int age; } ent_t;
   ent_t pend[$];
   logic [DW-1:0] mem_m [int];
   bit exp_valid = 0;
   logic [DW-1:0] exp_data;
   bit b_act = 0;
   int b_dir, b_base, b_k;

   always @(posedge clk) begin
      ent_t e;
      ent_t n;
      logic [DW-1:0] w;
      int lo;
      if (!rst_n) begin
         pend.delete();
         exp_valid = 0;
         b_act = 0;
      end else if (clk_en) begin
         foreach (pend[i]) pend[i].age++;
         if (pend.size() > 0 && pend[0].age == 2) begin
            e = pend.pop_front();
            if (e.op == 2) begin
               w = mem_m.exists(e.a) ? mem_m[e.a] : 'x;
               for (int l = 0; l < NL; l++)
                  if (e.be[l]) w[l*LW +: LW] = dq_in[l*LW +: LW];
               mem_m[e.a] = w;
               exp_valid = 0;
            end else if (e.op == 1) begin
               exp_valid = 1;
               exp_data = mem_m.exists(e.a) ? mem_m[e.a] : 'x;
            end else begin
               exp_valid = 0;
            end
         end
         n.op = 0; n.a = 0; n.be = ~byte_en_n; n.age = 0;
         if (sleep) b_act = 0;
         else if (!adv_ld) begin
            if (!sel_a_n && sel_b && !sel_c_n) begin
               b_act = 1; b_dir = wr_n ? 1 : 2; b_base = int'(addr); b_k = 0; n.op = b_dir;
            end else b_act = 0;
         end else if (b_act) begin
            b_k = (b_k + 1) % 4;
            n.op = b_dir;
         end
         lo = lin_burst ? ((b_base % 4) + b_k) % 4 : ((b_base % 4) ^ b_k);
         n.a = (b_base / 4) * 4 + lo;
         pend.push_back(n);
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(posedge clk) begin
      bit exp_oe;
      #2;
      if (rst_n && !done) begin
         exp_oe = exp_valid && !oe_n && !sleep;
         checks++;
         if (dq_oe !== exp_oe) begin
            bad++;
            $display("FAIL %s: dq_oe=%b expected %b", cur_req, dq_oe, exp_oe);
         end else if (exp_oe && !$isunknown(exp_data) && dq_out !== exp_data) begin
            bad++;
            $display("FAIL %s: dq_out=%h expected %h", cur_req, dq_out, exp_data);
         end
      end
   end

   // ---------------- stimulus ----------------
   logic [DW-1:0] d1 = '0, d2 = '0;

   task automatic cyc(input bit sel, input bit adv, input bit wr, input int a,
                      input logic [NL-1:0] ben, input logic [DW-1:0] d);
      sel_a_n = !sel; sel_b = 1'b1; sel_c_n = 1'b0;
      adv_ld = adv; wr_n = !wr; addr = AW'(a); byte_en_n = ben;
      dq_in = d2; d2 = d1; d1 = d;
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [NL-1:0] ben, input logic [DW-1:0] d);
      cyc(1, 0, 1, a, ben, d);
   endtask
   task automatic rd(input int a);
      cyc(1, 0, 0, a, '1, '0);
   endtask
   task automatic nop(input int k);
      for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, '1, '0);
   endtask
   task automatic adv(input logic [DW-1:0] d);
      cyc(0, 1, 0, 0, '0, d);
   endtask
   task automatic stall(input int k);
      clk_en = 1'b0;
      repeat (k) @(negedge clk);
      clk_en = 1'b1;
   endtask
   task automatic rsel(input bit an, input bit b, input bit cn, input bit w, input int a);
      sel_a_n = an; sel_b = b; sel_c_n = cn; adv_ld = 0; wr_n = !w;
      addr = AW'(a); byte_en_n = '0;
      dq_in = d2; d2 = d1; d1 = {DW{1'b1}};
      @(negedge clk);
   endtask

   initial begin
      rst_n = 0; clk_en = 1; sel_a_n = 1; sel_b = 1; sel_c_n = 0; adv_ld = 0;
      wr_n = 1; lin_burst = 1; oe_n = 0; sleep = 0; byte_en_n = '1; addr = '0; dq_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10: reset state
      cur_req = "R10";
      checks++;
      if (dq_oe !== 1'b0) begin bad++; $display("FAIL R10: dq_oe=%b expected 0", dq_oe); end
      nop(2);

      cur_req = "R2";   // full writes, then R1 read latency
      wr(8'h10, '0, 36'h1_1111_1111);
      wr(8'h11, '0, 36'h2_2222_2222);
      wr(8'h12, '0, 36'h3_3333_3333);
      wr(8'h13, '0, 36'h4_4444_4444);
      nop(2);
      cur_req = "R1";
      rd(8'h10); rd(8'h11); rd(8'h12); rd(8'h13);
      nop(3);
      cur_req = "R2";   // partial: lanes 0 and 2 written
      wr(8'h10, 4'b1010, 36'hA_BCDE_F012);
      nop(2); rd(8'h10); nop(3);

      cur_req = "R3";   // back-to-back mix with forwarding
      wr(8'h20, '0, 36'h5_0505_0505);
      rd(8'h20);
      rd(8'h20);
      wr(8'h21, '0, 36'h6_0606_0606);
      rd(8'h10);
      wr(8'h20, 4'b0011, 36'hF_EDCB_A987);
      rd(8'h20);
      rd(8'h21);
      wr(8'h22, 4'b1110, 36'h7_7777_7777);
      rd(8'h22);
      nop(3);

      cur_req = "R4";   // clock enable suspension
      wr(8'h30, '0, 36'h8_1234_5678);
      rd(8'h11);
      stall(3);
      rd(8'h30);
      stall(2);
      rd(8'h30);
      nop(3);

      cur_req = "R5";   // each select off, read and write
      rsel(1, 1, 0, 0, 8'h11); rsel(0, 0, 0, 0, 8'h11); rsel(0, 1, 1, 0, 8'h11);
      rsel(1, 1, 0, 1, 8'h12); rsel(0, 0, 0, 1, 8'h12); rsel(0, 1, 1, 1, 8'h12);
      nop(2); rd(8'h12); nop(3);

      cur_req = "R6";   // asynchronous output enable
      rd(8'h11); rd(8'h12);
      nop(1);
      oe_n = 1; nop(1);
      oe_n = 0; nop(1);
      rd(8'h13); nop(1);
      oe_n = 1; nop(1);
      oe_n = 0; nop(2);

      cur_req = "R7";   // sleep
      sleep = 1;
      wr(8'h13, '0, 36'h9_9999_9999);
      rd(8'h11);
      nop(2);
      sleep = 0;
      rd(8'h13);
      rd(8'h12);
      nop(1);
      sleep = 1; nop(1);
      sleep = 0; nop(3);

      cur_req = "R8";   // bursts
      lin_burst = 1;
      wr(8'h42, '0, 36'h0_4242_4242);
      adv(36'h0_4343_4343);
      adv(36'h0_4040_4040);
      adv(36'h0_4141_4141);
      lin_burst = 0;
      rd(8'h41); adv('0); adv('0); adv('0);
      lin_burst = 1;
      rd(8'h43); adv('0); adv('0); adv('0); adv('0);
      lin_burst = 0;
      wr(8'h41, 4'b1100, 36'h1_2345_6789);
      adv(36'h2_3456_789A);
      rd(8'h40); adv('0);
      nop(3);

      cur_req = "R9";   // advance with no burst
      adv('0); adv('0);
      nop(1); adv('0);
      rd(8'h40); sleep = 1; adv('0); sleep = 0; adv('0); adv('0);
      nop(4);

      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; bad++;
         $display("FAIL R10: watchdog finished=0 expected 1");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule